// File: doc/BRIEF.md
# Flash Program/Erase Fault Lockout Controller

This block sits between the control registers of an on-chip flash memory and the flash array. Software writes a mode register that asks for program, erase, program-verify or erase-verify, and a block-enable register that selects the flash blocks to work on. The block turns these bits into one active mode strobe toward the array.

While a program or erase strobe is active, the block watches four kinds of system event: a read of the flash array, entry to a non-reset exception, entry to sleep or software standby, and the bus being granted to a master other than the CPU. Any of these aborts the operation and raises a sticky fault flag. While the flag is set, program and erase cannot be restarted, but both verify modes stay usable and all register contents are kept. Only a synchronous reset or the hardware-standby input clears the flag.

Top module: `flash_guard_ctrl`

## Requirements
- R1: A flash read strobe (`flash_rd`) seen while the program or erase strobe is high sets `err_flag` on the next clock edge. This covers vector reads and instruction fetches.
- R2: Exception entry (`exc_entry`) while program or erase is active sets `err_flag` on the next edge, unless `exc_is_reset` is high in the same cycle.
- R3: Sleep or software-standby entry (`sleep_entry`) while program or erase is active sets `err_flag` on the next edge.
- R4: A grant of the bus to a non-CPU master (`xmaster_grant`) while program or erase is active sets `err_flag` on the next edge.
- R5: In the cycle after `err_flag` rises, the program and erase strobes are low. The mode bits and the block-enable register keep their contents.
- R6: While `err_flag` is high, writing the program bit or the erase bit does not raise `prog_strobe` or `erase_strobe`.
- R7: While `err_flag` is high, the verify bits can still be written and raise `pverify_strobe` or `everify_strobe`.
- R8: `err_flag` stays high until `rst` or `hw_stby`. No register write clears it, and `rst` returns every register and output to zero.
- R9: The four fault events have no effect while neither program nor erase is active, and this includes the verify modes.
- R10: Bit 7 of `mode_rd` reports `err_flag`. Writes to that bit position are ignored in both directions.
- R11: While `hw_stby` is high, the flag, the mode bits and the block-enable register are cleared on each edge. After release the block is idle and accepts new writes.
- R12: Mode register (`wr_sel`=0): bit0 program, bit1 erase, bit2 program-verify, bit3 erase-verify. Block register: `wr_sel`=1. At most one strobe is high at a time, with priority program > erase > program-verify > erase-verify. Program and erase take part in this priority only while unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_stby | input | 1 | Hardware standby; clears all state while high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the mode register, 1 selects the block-enable register |
| wr_data | input | 8 | Write data |
| flash_rd | input | 1 | Flash array read (data, vector or fetch) |
| exc_entry | input | 1 | Exception handling entered |
| exc_is_reset | input | 1 | The exception being entered is a reset |
| sleep_entry | input | 1 | Sleep or software standby entered |
| xmaster_grant | input | 1 | Bus granted to a non-CPU master |
| prog_strobe | output | 1 | Program mode active at the array |
| erase_strobe | output | 1 | Erase mode active at the array |
| pverify_strobe | output | 1 | Program-verify mode active |
| everify_strobe | output | 1 | Erase-verify mode active |
| err_flag | output | 1 | Sticky fault flag |
| mode_rd | output | 8 | Mode register readback, bit 7 the fault flag |
| blk_rd | output | 8 | Block-enable register readback |

## Verification
A vector table pairs each mode setting with each fault event, one at a time and all together. This separates events that must abort from events that must be ignored: a reset-type exception, and any event in the idle or verify modes. Rows that enable program and a verify bit together, or program and erase together, show the priority order and show that verify takes over once program is locked out. Directed sequences then rewrite the program, erase, verify and flag bits under lock, and leave through hardware standby and through reset. These sequences tell the sticky gating apart from a plain register clear.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    localparam int SEL_MODE = 0;
    localparam int SEL_BLK  = 1;

    typedef struct packed {
        logic ev;   // erase-verify request
        logic pv;   // program-verify request
        logic er;   // erase request
        logic pg;   // program request
    } mode_bits_t;

    localparam int MODE_BITS = $bits(mode_bits_t);

    typedef enum logic [2:0] {
        MODE_IDLE  = 3'd0,
        MODE_PROG  = 3'd1,
        MODE_ERASE = 3'd2,
        MODE_PVFY  = 3'd3,
        MODE_EVFY  = 3'd4
    } mode_e;

    typedef struct packed {
        logic rd;
        logic exc;
        logic exc_rst;
        logic sleep;
        logic xm;
    } fault_evt_t;

    function automatic mode_e pick_mode(mode_bits_t b, logic lock);
        if (b.pg && !lock)      return MODE_PROG;
        else if (b.er && !lock) return MODE_ERASE;
        else if (b.pv)          return MODE_PVFY;
        else if (b.ev)          return MODE_EVFY;
        return MODE_IDLE;
    endfunction

    function automatic logic fault_hit(fault_evt_t e);
        return e.rd | (e.exc & ~e.exc_rst) | e.sleep | e.xm;
    endfunction

endpackage

// File: rtl/flash_guard_regs.sv
module flash_guard_regs
    import flash_guard_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BLK_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_stby,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output mode_bits_t        mode_q,
    output logic [BLK_W-1:0]  blk_q
);

    always_ff @(posedge clk) begin
        if (rst || hw_stby) begin
            mode_q <= '0;
            blk_q  <= '0;
        end else if (wr_en) begin
            if (wr_sel == 1'(SEL_MODE))
                mode_q <= mode_bits_t'(wr_data[MODE_BITS-1:0]);
            else
                blk_q  <= wr_data[BLK_W-1:0];
        end
    end

endmodule

// File: rtl/flash_guard_fault.sv
module flash_guard_fault
    import flash_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hw_stby,
    input  logic       pe_active,
    input  fault_evt_t evt,
    output logic       lock_q
);

    logic hit;

    always_comb hit = pe_active & fault_hit(evt);

    always_ff @(posedge clk) begin
        if (rst || hw_stby)
            lock_q <= 1'b0;
        else if (hit)
            lock_q <= 1'b1;
    end

endmodule

// File: rtl/flash_guard_mode.sv
module flash_guard_mode
    import flash_guard_pkg::*;
(
    input  mode_bits_t mode_q,
    input  logic       lock,
    output mode_bits_t strobe
);

    mode_e cur;

    always_comb cur = pick_mode(mode_q, lock);

    for (genvar i = 0; i < MODE_BITS; i++) begin : g_strb
        assign strobe[i] = (cur == mode_e'(3'(i + 1)));
    end

endmodule

// File: rtl/flash_guard_ctrl.sv
module flash_guard_ctrl
    import flash_guard_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BLK_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_stby,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flash_rd,
    input  logic              exc_entry,
    input  logic              exc_is_reset,
    input  logic              sleep_entry,
    input  logic              xmaster_grant,
    output logic              prog_strobe,
    output logic              erase_strobe,
    output logic              pverify_strobe,
    output logic              everify_strobe,
    output logic              err_flag,
    output logic [DATA_W-1:0] mode_rd,
    output logic [BLK_W-1:0]  blk_rd
);

    localparam int ERR_POS = DATA_W - 1;

    mode_bits_t mode_q;
    mode_bits_t strobe;
    fault_evt_t evt;
    logic       lock_q;

    flash_guard_regs #(.DATA_W(DATA_W), .BLK_W(BLK_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .hw_stby (hw_stby),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .mode_q  (mode_q),
        .blk_q   (blk_rd)
    );

    flash_guard_mode u_mode (
        .mode_q (mode_q),
        .lock   (lock_q),
        .strobe (strobe)
    );

    always_comb begin
        evt.rd      = flash_rd;
        evt.exc     = exc_entry;
        evt.exc_rst = exc_is_reset;
        evt.sleep   = sleep_entry;
        evt.xm      = xmaster_grant;
    end

    flash_guard_fault u_fault (
        .clk       (clk),
        .rst       (rst),
        .hw_stby   (hw_stby),
        .pe_active (strobe.pg | strobe.er),
        .evt       (evt),
        .lock_q    (lock_q)
    );

    always_comb begin
        mode_rd                  = '0;
        mode_rd[MODE_BITS-1:0]   = mode_q;
        mode_rd[ERR_POS]         = lock_q;
        prog_strobe              = strobe.pg;
        erase_strobe             = strobe.er;
        pverify_strobe           = strobe.pv;
        everify_strobe           = strobe.ev;
        err_flag                 = lock_q;
    end

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
    parameter int DATA_W = 8,
    parameter int BLK_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              hw_stby,
    input logic              wr_en,
    input logic              flash_rd,
    input logic              exc_entry,
    input logic              exc_is_reset,
    input logic              sleep_entry,
    input logic              xmaster_grant,
    input logic              prog_strobe,
    input logic              erase_strobe,
    input logic              pverify_strobe,
    input logic              everify_strobe,
    input logic              err_flag,
    input logic [DATA_W-1:0] mode_rd,
    input logic [BLK_W-1:0]  blk_rd
);

    logic pe_on;
    logic evt_any;

    always_comb begin
        pe_on   = prog_strobe | erase_strobe;
        evt_any = flash_rd | (exc_entry & ~exc_is_reset) | sleep_entry | xmaster_grant;
    end

    // R12
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({prog_strobe, erase_strobe, pverify_strobe, everify_strobe}));

    // R6
    lock_blocks_pe_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> !pe_on);

    // R1 R2 R3 R4
    fault_sets_flag_chk: assert property (@(posedge clk) disable iff (rst || hw_stby)
        (pe_on && evt_any) |=> err_flag);

    // R9
    flag_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> $past(pe_on));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst || hw_stby)
        err_flag |=> err_flag);

    // R5
    regs_kept_chk: assert property (@(posedge clk) disable iff (rst || hw_stby)
        (err_flag && !wr_en) |=> ($stable(blk_rd) && $stable(mode_rd)));

    // R11
    stby_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(hw_stby) |-> (!err_flag && mode_rd == '0 && blk_rd == '0));

endmodule

bind flash_guard_ctrl flash_guard_chk #(.DATA_W(DATA_W), .BLK_W(BLK_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .hw_stby        (hw_stby),
    .wr_en          (wr_en),
    .flash_rd       (flash_rd),
    .exc_entry      (exc_entry),
    .exc_is_reset   (exc_is_reset),
    .sleep_entry    (sleep_entry),
    .xmaster_grant  (xmaster_grant),
    .prog_strobe    (prog_strobe),
    .erase_strobe   (erase_strobe),
    .pverify_strobe (pverify_strobe),
    .everify_strobe (everify_strobe),
    .err_flag       (err_flag),
    .mode_rd        (mode_rd),
    .blk_rd         (blk_rd)
);

// File: tb/sim_flash_guard_ctrl.sv
module sim_flash_guard_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hw_stby = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       flash_rd = 1'b0;
    logic       exc_entry = 1'b0;
    logic       exc_is_reset = 1'b0;
    logic       sleep_entry = 1'b0;
    logic       xmaster_grant = 1'b0;
    logic       prog_strobe, erase_strobe, pverify_strobe, everify_strobe, err_flag;
    logic [7:0] mode_rd, blk_rd;

    int  n_cmp = 0;
    int  n_bad = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    flash_guard_ctrl u0 (
        .clk(clk), .rst(rst), .hw_stby(hw_stby), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .flash_rd(flash_rd), .exc_entry(exc_entry),
        .exc_is_reset(exc_is_reset), .sleep_entry(sleep_entry),
        .xmaster_grant(xmaster_grant), .prog_strobe(prog_strobe),
        .erase_strobe(erase_strobe), .pverify_strobe(pverify_strobe),
        .everify_strobe(everify_strobe), .err_flag(err_flag),
        .mode_rd(mode_rd), .blk_rd(blk_rd)
    );

    // row: [13:10] mode {ev,pv,er,pg}, [9:5] events {xm,sleep,exc_rst,exc,rd},
    //      [4] expected flag, [3:0] expected strobes {ev,pv,er,pg}
    localparam int NV = 11;
    localparam logic [13:0] VEC [NV] = '{
        {4'b0001, 5'b00001, 1'b1, 4'b0000},  // R1 program + read
        {4'b0010, 5'b00010, 1'b1, 4'b0000},  // R2 erase + exception
        {4'b0001, 5'b00110, 1'b0, 4'b0001},  // R2 reset-type exception ignored
        {4'b0010, 5'b01000, 1'b1, 4'b0000},  // R3 erase + sleep
        {4'b0001, 5'b10000, 1'b1, 4'b0000},  // R4 program + foreign master
        {4'b0100, 5'b00001, 1'b0, 4'b0100},  // R9 program-verify + read
        {4'b1000, 5'b01000, 1'b0, 4'b1000},  // R9 erase-verify + sleep
        {4'b0000, 5'b11111, 1'b0, 4'b0000},  // R9 idle + everything
        {4'b0101, 5'b00001, 1'b1, 4'b0100},  // R7 verify takes over after lock
        {4'b0011, 5'b00000, 1'b0, 4'b0001},  // R12 program beats erase
        {4'b1010, 5'b10000, 1'b1, 4'b1000}   // R5 erase aborted, erase-verify remains
    };
    string TAG [NV] = '{"R1","R2","R2","R3","R4","R9","R9","R9","R7","R12","R5"};

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [3:0] strobes();
        return {everify_strobe, pverify_strobe, erase_strobe, prog_strobe};
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic fire(input logic [4:0] e);
        {xmaster_grant, sleep_entry, exc_is_reset, exc_entry, flash_rd} = e;
        @(negedge clk);
        {xmaster_grant, sleep_entry, exc_is_reset, exc_entry, flash_rd} = '0;
    endtask

    initial begin
        // vector walk
        for (int k = 0; k < NV; k++) begin
            do_reset();
            wr(1'b0, {4'b0, VEC[k][13:10]});
            fire(VEC[k][9:5]);
            check({TAG[k], " flag"}, 32'(err_flag), 32'(VEC[k][4]));
            check({TAG[k], " strobes"}, 32'(strobes()), 32'(VEC[k][3:0]));
        end

        // reset state (R8)
        do_reset();
        check("R8 reset flag", 32'(err_flag), 0);
        check("R8 reset mode_rd", 32'(mode_rd), 0);
        check("R8 reset blk_rd", 32'(blk_rd), 0);
        check("R8 reset strobes", 32'(strobes()), 0);

        // abort keeps registers (R5, R10)
        wr(1'b1, 8'hA5);
        wr(1'b0, 8'h01);
        check("R12 program strobe", 32'(strobes()), 32'h1);
        fire(5'b00001);
        check("R1 flag after read", 32'(err_flag), 1);
        check("R5 strobes dropped", 32'(strobes()), 0);
        check("R10 mode_rd shows flag and bits", 32'(mode_rd), 32'h81);
        check("R5 block reg kept", 32'(blk_rd), 32'hA5);

        // re-entry blocked (R6)
        wr(1'b0, 8'h01);
        check("R6 program blocked", 32'(prog_strobe), 0);
        wr(1'b0, 8'h02);
        check("R6 erase blocked", 32'(erase_strobe), 0);
        check("R6 flag still set", 32'(err_flag), 1);

        // verify allowed (R7)
        wr(1'b0, 8'h04);
        check("R7 program-verify under lock", 32'(strobes()), 32'h4);
        wr(1'b0, 8'h08);
        check("R7 erase-verify under lock", 32'(strobes()), 32'h8);

        // software cannot clear (R8, R10)
        wr(1'b0, 8'h00);
        check("R8 write zero keeps flag", 32'(err_flag), 1);
        check("R10 mode_rd after zero write", 32'(mode_rd), 32'h80);

        // hardware standby (R11)
        @(negedge clk); hw_stby = 1'b1;
        @(negedge clk);
        check("R11 standby flag", 32'(err_flag), 0);
        check("R11 standby mode_rd", 32'(mode_rd), 0);
        check("R11 standby blk_rd", 32'(blk_rd), 0);
        @(negedge clk); hw_stby = 1'b0;
        @(negedge clk);
        check("R11 idle after release", 32'(strobes()), 0);
        wr(1'b0, 8'h01);
        check("R11 program accepted after standby", 32'(strobes()), 32'h1);

        // flag bit write ignored when clear (R10)
        do_reset();
        wr(1'b0, 8'h80);
        check("R10 write one to flag bit", 32'(err_flag), 0);
        check("R10 mode_rd after flag write", 32'(mode_rd), 0);

        // reset clears lock (R8)
        wr(1'b0, 8'h02);
        fire(5'b01000);
        check("R3 flag before reset", 32'(err_flag), 1);
        do_reset();
        check("R8 reset clears flag", 32'(err_flag), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule